// File: doc/BRIEF.md
# LIN Master Response-Receive Sequencer

This block is the master end of a LIN bus for frames in which a slave supplies the response. Software or a DMA channel hands it a four-byte command. The block then runs the whole frame on its own.

It first drives the header to a byte-level line transmitter: a break, the sync byte 0x55 and the protected identifier. It then collects the slave's data bytes from a byte-level line receiver. Each data byte is presented in a read register with a ready flag. The optional trailing CRC byte and checksum byte are verified inside the block and never shown to the reader.

Sticky flags report frame completion, CRC mismatch, checksum mismatch, response timeout and commands written while busy. Bit timing, bit sampling and wake-up handling sit outside this block. A bit-time strobe input drives the timeout.

Top module: `lin_rxs_master`

## Requirements
- R1: Command bytes are taken in sequence. Byte 1 is the protected identifier, sent unchanged. Byte 2 is the number of data bytes expected. Byte 3 is laid out as: bit 7 direction, bit 6 CRC enable, bit 5 checksum enable, bit 4 enhanced checksum select, bits 3:0 timeout bits 11:8. Byte 4 is timeout bits 7:0. A frame starts right after byte 4 when the direction bit is 0.
- R2: A command whose byte 3 has bit 7 set starts no frame. No header is sent and no flag is raised. The next byte is again taken as byte 1.
- R3: The header goes out as a break request (`phy_tx_break`=1), then byte 0x55, then the identifier. Each item is held on `phy_tx_valid`/`phy_tx_byte` until `phy_tx_done` is seen.
- R4: In the data phase, each byte received is placed on `rd_data` and sets `rx_ready`. `rx_ready_clr` clears `rx_ready`, and a new byte takes priority over the clear.
- R5: The CRC byte (first, when enabled) and the checksum byte (when enabled) follow the data bytes. Neither changes `rd_data` or `rx_ready`.
- R6: The expected checksum is the inverted 8-bit end-around-carry sum of the data bytes. In enhanced mode the identifier is included in the sum. A mismatch sets `cks_err`.
- R7: The expected CRC is CRC-8 with polynomial 0x1D and initial value 0xFF, computed MSB first over the data bytes. A mismatch sets `crc_err`.
- R8: `frame_done` is set when the last expected byte of the frame has been received. This holds even when a CRC or checksum mismatch was found.
- R9: After the identifier has been sent, `bit_tick` pulses are counted. If the count reaches a nonzero programmed timeout before the frame ends, the frame is abandoned, `timeout_err` is set and `frame_done` is not set. A timeout value of 0 disables the count.
- R10: A command byte offered while a frame is pending or running is dropped and sets `overrun_err`. The running frame is unchanged, and the command sequence position is unchanged.
- R11: With `dma_en`=1, `tx_dreq` is high whenever no frame is pending or running. Command bytes are then taken on `tx_dack` instead of `cmd_wr`.
- R12: With `dma_en`=1, `rx_dreq` is high while a data byte is ready. `rx_dack` clears `rx_ready`.
- R13: All five flags stay set until `flag_clr` is pulsed. A flag event in the same cycle as `flag_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command byte strobe (register access) |
| cmd_data | input | 8 | Command byte, for both register access and DMA |
| dma_en | input | 1 | Selects DMA mode |
| tx_dreq | output | 1 | DMA request for the next command byte |
| tx_dack | input | 1 | DMA acknowledge; command byte valid on `cmd_data` |
| bit_tick | input | 1 | One pulse per bit time |
| phy_tx_valid | output | 1 | Header item request to the line transmitter |
| phy_tx_break | output | 1 | The current item is a break |
| phy_tx_byte | output | 8 | Header byte to send |
| phy_tx_done | input | 1 | The line transmitter has finished the current item |
| phy_rx_valid | input | 1 | Byte received from the line |
| phy_rx_byte | input | 8 | Received byte |
| rd_data | output | 8 | Last data byte received |
| rx_ready | output | 1 | A data byte is waiting |
| rx_ready_clr | input | 1 | Clears `rx_ready` |
| rx_dreq | output | 1 | DMA request to fetch `rd_data` |
| rx_dack | input | 1 | DMA acknowledge of the data byte |
| flag_clr | input | 1 | Clears all sticky flags |
| frame_done | output | 1 | The frame was fully received |
| crc_err | output | 1 | CRC mismatch |
| cks_err | output | 1 | Checksum mismatch |
| timeout_err | output | 1 | Response timeout |
| overrun_err | output | 1 | Command byte offered while busy |

## Verification
The bench builds the block with the default 12-bit timeout counter. It programs small limits (5 bit times) so that expiry is reached within a few strobes. It also programs a limit of 0 and then supplies many strobes, which shows that the count is disabled. Response lengths of 0, 1, 2 and 3 bytes cover:
- the direct jump from the identifier to the trailing fields,
- every combination of the CRC and checksum enables,
- both checksum variants.

Command bytes are delivered both by register writes and by the DMA handshake.

// File: rtl/lin_rxs_pkg.sv
package lin_rxs_pkg;

  localparam int TMO_HI_W = 4;
  localparam int TMO_W    = 8 + TMO_HI_W;

  localparam logic [7:0] SYNC_BYTE = 8'h55;
  localparam logic [7:0] CRC_POLY  = 8'h1D;
  localparam logic [7:0] CRC_INIT  = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BRK, ST_SYN, ST_PID, ST_DATA, ST_CRC, ST_CKS
  } lin_st_e;

  typedef struct packed {
    logic [7:0]       pid;
    logic [7:0]       len;
    logic             crc_en;
    logic             cks_en;
    logic             enh;
    logic [TMO_W-1:0] tmo;
  } lin_cfg_t;

  // 8-bit add with the carry folded back in
  function automatic logic [7:0] cks_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'b0, s[8]};
  endfunction

  // one byte through the CRC-8 register, MSB first
  function automatic logic [7:0] crc8_upd(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++)
      r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction

endpackage

// File: rtl/lin_rxs_cmd.sv
module lin_rxs_cmd
  import lin_rxs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     acc,
  input  logic [7:0] din,
  input  logic     busy,
  output lin_cfg_t cfg,
  output logic     start,
  output logic     ovr_evt
);

  logic [1:0] idx;
  logic [7:0] b_pid, b_len, b_ctl, b_lo;
  logic       take;

  assign take    = acc && !busy;
  assign ovr_evt = acc && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      b_pid <= '0;
      b_len <= '0;
      b_ctl <= '0;
      b_lo  <= '0;
      start <= 1'b0;
    end else begin
      start <= take && (idx == 2'd3) && !b_ctl[7];
      if (take) begin
        idx <= idx + 2'd1;
        case (idx)
          2'd0:    b_pid <= din;
          2'd1:    b_len <= din;
          2'd2:    b_ctl <= din;
          default: b_lo  <= din;
        endcase
      end
    end
  end

  assign cfg.pid    = b_pid;
  assign cfg.len    = b_len;
  assign cfg.crc_en = b_ctl[6];
  assign cfg.cks_en = b_ctl[5];
  assign cfg.enh    = b_ctl[4];
  assign cfg.tmo    = {b_ctl[TMO_HI_W-1:0], b_lo};

  a_r2_dir_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx == 2'd3 && b_ctl[7]) |=> !start);

endmodule

// File: rtl/lin_rxs_chk.sv
module lin_rxs_chk
  import lin_rxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       enh,
  input  logic [7:0] pid,
  input  logic       data_evt,
  input  logic [7:0] data,
  output logic [7:0] cks_exp,
  output logic [7:0] crc_exp
);

  logic [7:0] sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum     <= '0;
      crc_exp <= CRC_INIT;
    end else if (init) begin
      sum     <= enh ? pid : 8'h00;
      crc_exp <= CRC_INIT;
    end else if (data_evt) begin
      sum     <= cks_add(sum, data);
      crc_exp <= crc8_upd(crc_exp, data);
    end
  end

  assign cks_exp = ~sum;

endmodule

// File: rtl/lin_rxs_tmo.sv
module lin_rxs_tmo #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expire
);

  logic [W-1:0] cnt;

  assign expire = run && (limit != '0) && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run)          cnt <= '0;
    else if (tick && !expire) cnt <= cnt + 1'b1;
  end

  a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (run && limit != '0 && $past(run)) |-> (cnt <= limit));

endmodule

// File: rtl/lin_rxs_master.sv
module lin_rxs_master
  import lin_rxs_pkg::*;
#(
  parameter int TW = TMO_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_data,
  input  logic       dma_en,
  output logic       tx_dreq,
  input  logic       tx_dack,
  input  logic       bit_tick,
  output logic       phy_tx_valid,
  output logic       phy_tx_break,
  output logic [7:0] phy_tx_byte,
  input  logic       phy_tx_done,
  input  logic       phy_rx_valid,
  input  logic [7:0] phy_rx_byte,
  output logic [7:0] rd_data,
  output logic       rx_ready,
  input  logic       rx_ready_clr,
  output logic       rx_dreq,
  input  logic       rx_dack,
  input  logic       flag_clr,
  output logic       frame_done,
  output logic       crc_err,
  output logic       cks_err,
  output logic       timeout_err,
  output logic       overrun_err
);

  lin_st_e    state;
  lin_cfg_t   cfg;
  logic       start, busy, cmd_acc, ovr_evt;
  logic [7:0] rem, cks_exp, crc_exp;
  logic       tmo_run, tmo_expire;
  logic       hdr_done, data_evt, crc_evt, cks_evt, fin_evt, data_last;
  lin_st_e    trail_st;

  assign busy    = (state != ST_IDLE) || start;
  assign cmd_acc = dma_en ? tx_dack : cmd_wr;
  assign tx_dreq = dma_en && !busy;
  assign rx_dreq = dma_en && rx_ready;

  lin_rxs_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .acc(cmd_acc), .din(cmd_data), .busy(busy),
    .cfg(cfg), .start(start), .ovr_evt(ovr_evt)
  );

  assign tmo_run = (state == ST_DATA) || (state == ST_CRC) || (state == ST_CKS);

  lin_rxs_tmo #(.W(TW)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(tmo_run), .tick(bit_tick),
    .limit(cfg.tmo[TW-1:0]), .expire(tmo_expire)
  );

  // named events for the datapath and assertions
  assign hdr_done  = (state == ST_PID) && phy_tx_done;
  assign data_evt  = (state == ST_DATA) && phy_rx_valid && !tmo_expire;
  assign crc_evt   = (state == ST_CRC)  && phy_rx_valid && !tmo_expire;
  assign cks_evt   = (state == ST_CKS)  && phy_rx_valid && !tmo_expire;
  assign data_last = data_evt && (rem == 8'd1);
  assign trail_st  = cfg.crc_en ? ST_CRC : (cfg.cks_en ? ST_CKS : ST_IDLE);
  assign fin_evt   = ((hdr_done && cfg.len == 8'd0) || data_last) && trail_st == ST_IDLE
                   || (crc_evt && !cfg.cks_en) || cks_evt;

  lin_rxs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .init(start), .enh(cfg.enh), .pid(cfg.pid),
    .data_evt(data_evt), .data(phy_rx_byte), .cks_exp(cks_exp), .crc_exp(crc_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rem   <= '0;
    end else if (tmo_expire) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_BRK;
        ST_BRK:  if (phy_tx_done) state <= ST_SYN;
        ST_SYN:  if (phy_tx_done) state <= ST_PID;
        ST_PID:  if (phy_tx_done) begin
                   rem   <= cfg.len;
                   state <= (cfg.len == 8'd0) ? trail_st : ST_DATA;
                 end
        ST_DATA: if (data_evt) begin
                   rem <= rem - 8'd1;
                   if (rem == 8'd1) state <= trail_st;
                 end
        ST_CRC:  if (crc_evt) state <= cfg.cks_en ? ST_CKS : ST_IDLE;
        ST_CKS:  if (cks_evt) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    phy_tx_valid = (state == ST_BRK) || (state == ST_SYN) || (state == ST_PID);
    phy_tx_break = (state == ST_BRK);
    case (state)
      ST_SYN:  phy_tx_byte = SYNC_BYTE;
      ST_PID:  phy_tx_byte = cfg.pid;
      default: phy_tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rx_ready <= 1'b0;
    end else begin
      if (data_evt) rd_data <= phy_rx_byte;
      if (data_evt) rx_ready <= 1'b1;
      else if (rx_ready_clr || (dma_en && rx_dack)) rx_ready <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_done  <= 1'b0;
      crc_err     <= 1'b0;
      cks_err     <= 1'b0;
      timeout_err <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      frame_done  <= fin_evt ? 1'b1 : (flag_clr ? 1'b0 : frame_done);
      crc_err     <= (crc_evt && phy_rx_byte != crc_exp) ? 1'b1 : (flag_clr ? 1'b0 : crc_err);
      cks_err     <= (cks_evt && phy_rx_byte != cks_exp) ? 1'b1 : (flag_clr ? 1'b0 : cks_err);
      timeout_err <= tmo_expire ? 1'b1 : (flag_clr ? 1'b0 : timeout_err);
      overrun_err <= ovr_evt ? 1'b1 : (flag_clr ? 1'b0 : overrun_err);
    end
  end

  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_tx_valid && !phy_tx_done) |=> (phy_tx_valid && $stable(phy_tx_byte) && $stable(phy_tx_break)));
  a_r4_byte_out: assert property (@(posedge clk) disable iff (!rst_n)
    data_evt |=> (rx_ready && rd_data == $past(phy_rx_byte)));
  a_r5_trail_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_evt || cks_evt) |=> $stable(rd_data));
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> (frame_done && state == ST_IDLE));
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_expire |=> (timeout_err && state == ST_IDLE));
  a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> overrun_err);
  a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !flag_clr) |=> timeout_err);

endmodule

// File: tb/lin_rxs_master_bench.sv
`timescale 1ns/1ps
module lin_rxs_master_bench;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, dma_en = 0, tx_dack = 0, bit_tick = 0, phy_tx_done = 0;
  logic phy_rx_valid = 0, rx_ready_clr = 0, rx_dack = 0, flag_clr = 0;
  logic [7:0] cmd_data = 0, phy_rx_byte = 0;
  logic tx_dreq, phy_tx_valid, phy_tx_break, rx_ready, rx_dreq;
  logic frame_done, crc_err, cks_err, timeout_err, overrun_err;
  logic [7:0] phy_tx_byte, rd_data;

  int checks = 0, failures = 0;
  bit finished = 0;
  int txq[$];

  always #2.5 clk = ~clk;

  lin_rxs_master u_lin_rxs_master (.*);

  // line-transmitter model: completes each item three cycles after request
  initial begin
    int gap = 0;
    forever begin
      @(negedge clk);
      phy_tx_done = 0;
      if (phy_tx_valid) begin
        gap++;
        if (gap == 3) begin
          txq.push_back(phy_tx_break ? 256 : int'(phy_tx_byte));
          phy_tx_done = 1;
          gap = 0;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference arithmetic, written independently
  function automatic int ref_cks(input int pid, input bit enh, input int d[$]);
    int s = enh ? pid : 0;
    foreach (d[i]) s += d[i];
    while (s > 255) s = (s & 255) + (s >> 8);
    return (~s) & 255;
  endfunction

  function automatic int ref_crc(input int d[$]);
    int r = 'hFF;
    foreach (d[i]) begin
      for (int b = 7; b >= 0; b--) begin
        int fb = ((r >> 7) ^ (d[i] >> b)) & 1;
        r = ((r << 1) & 255) ^ (fb ? 'h1D : 0);
      end
    end
    return r;
  endfunction

  task automatic put_cmd(input int b);
    @(negedge clk);
    if (dma_en) tx_dack = 1; else cmd_wr = 1;
    cmd_data = b[7:0];
    @(negedge clk);
    tx_dack = 0; cmd_wr = 0;
  endtask

  task automatic send_rx(input int b);
    @(negedge clk);
    phy_rx_valid = 1; phy_rx_byte = b[7:0];
    @(negedge clk);
    phy_rx_valid = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic wait_header(input int pid);
    int w = 0;
    while (txq.size() < 3 && w < 200) begin @(negedge clk); #1; w++; end
    @(negedge clk);
    check("R3 header count", txq.size(), 3);
    if (txq.size() == 3) begin
      check("R3 break first", txq[0], 256);
      check("R3 sync second", txq[1], 'h55);
      check("R1 pid third", txq[2], pid);
    end
    txq.delete();
  endtask

  // full register-driven frame
  task automatic run_frame(input int pid, input int n, input bit ce, input bit ke,
                           input bit enh, input bit bad_crc, input bit bad_cks);
    int d[$];
    int last = rd_data;
    for (int k = 0; k < n; k++) d.push_back((8'h3C + k * 8'h29) & 255);
    put_cmd(pid); put_cmd(n); put_cmd({ce, ke, enh, 4'h0}); put_cmd(0);
    wait_header(pid);
    foreach (d[i]) begin
      send_rx(d[i]);
      #1;
      check("R4 rd_data", rd_data, d[i]);
      check("R4 rx_ready set", rx_ready, 1);
      last = d[i];
      @(negedge clk); rx_ready_clr = 1;
      @(negedge clk); rx_ready_clr = 0; #1;
      check("R4 rx_ready cleared", rx_ready, 0);
    end
    if (ce) begin
      send_rx(ref_crc(d) ^ (bad_crc ? 1 : 0)); #1;
      check("R5 crc hidden data", rd_data, last);
      check("R5 crc hidden ready", rx_ready, 0);
    end
    if (ke) begin
      send_rx(ref_cks(pid, enh, d) ^ (bad_cks ? 'h80 : 0)); #1;
      check("R5 cks hidden data", rd_data, last);
    end
    @(negedge clk); #1;
    check("R8 frame_done", frame_done, 1);
    check("R7 crc_err", crc_err, ce && bad_crc);
    check("R6 cks_err", cks_err, ke && bad_cks);
    pulse_clr(); #1;
    check("R13 flags cleared", frame_done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset tx_valid", phy_tx_valid, 0);
    check("R4 reset rx_ready", rx_ready, 0);
    check("R8 reset frame_done", frame_done, 0);
    check("R11 reset tx_dreq", tx_dreq, 0);
    rst_n = 1;

    run_frame('hC1, 3, 1, 1, 0, 0, 0);
    run_frame('h92, 2, 1, 1, 1, 0, 1);
    run_frame('h50, 1, 1, 0, 0, 1, 0);
    run_frame('hA3, 2, 0, 1, 1, 0, 0);
    run_frame('h11, 1, 0, 0, 0, 0, 0);

    // R2: direction bit set -> no frame
    put_cmd('h42); put_cmd(1); put_cmd('h80); put_cmd(0);
    repeat (12) @(negedge clk); #1;
    check("R2 no header", txq.size(), 0);
    check("R2 no tx_valid", phy_tx_valid, 0);
    check("R2 no overrun", overrun_err, 0);
    run_frame('h64, 1, 0, 1, 0, 0, 0);

    // R10: write during a frame
    put_cmd('h2B); put_cmd(1); put_cmd('h20); put_cmd(0);
    put_cmd('hEE); #1;
    check("R10 overrun set", overrun_err, 1);
    wait_header('h2B);
    send_rx('h77); send_rx(ref_cks('h2B, 0, '{'h77}));
    @(negedge clk); #1;
    check("R10 frame unaffected", frame_done, 1);
    check("R10 cks ok", cks_err, 0);
    pulse_clr();
    run_frame('h3A, 2, 1, 1, 0, 0, 0);

    // R9: timeout of 5 bit times
    put_cmd('h1D); put_cmd(2); put_cmd('h00); put_cmd(5);
    wait_header('h1D);
    send_rx('h5A);
    for (int t = 0; t < 4; t++) begin
      @(negedge clk); bit_tick = 1; @(negedge clk); bit_tick = 0;
    end
    #1; check("R9 not yet", timeout_err, 0);
    @(negedge clk); bit_tick = 1; @(negedge clk); bit_tick = 0;
    @(negedge clk); #1;
    check("R9 timeout_err", timeout_err, 1);
    check("R9 no frame_done", frame_done, 0);
    send_rx('h12); #1;
    check("R9 aborted ignores rx", rd_data, 'h5A);
    repeat (3) @(negedge clk); #1;
    check("R13 timeout sticky", timeout_err, 1);
    pulse_clr();

    // R9: limit 0 disables, empty response with classic checksum
    put_cmd('h08); put_cmd(0); put_cmd('h20); put_cmd(0);
    wait_header('h08);
    for (int t = 0; t < 20; t++) begin
      @(negedge clk); bit_tick = 1; @(negedge clk); bit_tick = 0;
    end
    send_rx('hFF);
    @(negedge clk); #1;
    check("R9 zero limit no timeout", timeout_err, 0);
    check("R8 empty response done", frame_done, 1);
    check("R6 empty cks", cks_err, 0);
    pulse_clr();

    // R11/R12: DMA mode
    @(negedge clk); dma_en = 1; #1;
    check("R11 tx_dreq idle", tx_dreq, 1);
    put_cmd('h55); put_cmd(1); put_cmd('h30); #1;
    check("R11 tx_dreq between", tx_dreq, 1);
    put_cmd(0); #1;
    check("R11 tx_dreq busy", tx_dreq, 0);
    wait_header('h55);
    send_rx('h9C); #1;
    check("R12 rx_dreq", rx_dreq, 1);
    check("R12 rd_data", rd_data, 'h9C);
    @(negedge clk); rx_dack = 1; @(negedge clk); rx_dack = 0; #1;
    check("R12 rx_dack clears", rx_ready, 0);
    send_rx(ref_cks('h55, 1, '{'h9C}));
    @(negedge clk); #1;
    check("R8 dma done", frame_done, 1);
    check("R6 dma enhanced cks", cks_err, 0);
    check("R11 tx_dreq again", tx_dreq, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule